// File: doc/BRIEF.md
# Rotating Victim Pointer for a Fully Associative Buffer

This block picks which entry of a 64-entry fully associative buffer is overwritten when a new line has to be brought in. It holds one register, a replacement pointer, that always names a single entry. That entry is the current victim, and its index is driven straight out of the pointer with no logic between them.

The surrounding lookup logic reports every hit by pulsing an access strobe along with the index of the entry that matched. If that index is the one the pointer names, the pointer steps on to the following entry. Hits on any other entry leave it where it is. This approximates least-recently-used behaviour: an entry that keeps being hit keeps pushing the pointer off itself.

When the buffer needs room, the fill logic raises a fill request and writes into the entry the victim output names. The entry just filled counts as freshly used, so the pointer then steps past it. Tag matching and data storage stay outside this block.

Top module: `rrv_victim_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the victim output is 0.
- R2: The victim output always equals the pointer value, and it changes only at a rising clock edge.
- R3: A cycle with the access strobe high and the access index equal to the victim output moves the victim output to the next index at the following edge.
- R4: A cycle with the access strobe high, an access index different from the victim output and no fill request leaves the victim output unchanged.
- R5: While the access strobe is low, the access index has no effect, even when it equals the victim output.
- R6: Stepping is modulo 64. From index 63 the pointer goes to 0.
- R7: A cycle with the fill request high moves the victim output to the next index at the following edge.
- R8: A fill request together with an access to the pointed entry in the same cycle advances the pointer by exactly one.
- R9: A fill request together with an access to some other entry advances the pointer by exactly one, as a fill on its own would.
- R10: After any cycle with an access and no fill, the victim output differs from the index just accessed. An entry that is hit over and over is therefore never offered as victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | High for one cycle per reported hit |
| acc_idx | input | 6 | Index of the entry that was hit |
| fill_req | input | 1 | High when a fill writes the current victim entry |
| victim_idx | output | 6 | Entry to be replaced; equals the pointer |

## Verification
A hit on the pointed entry and a fill request can both arrive in the same cycle. Each of them would step the pointer on its own. The bench provokes this by raising the fill request and the access strobe together, with the index set to the current victim output. It also pairs a fill with a hit on a different entry, and it mixes both cases into a pseudo-random stream. In every one of these cycles the result is judged against a behavioural model that allows a move of exactly one step, including the step from 63 back to 0.

// File: rtl/rrv_pkg.sv
`timescale 1ns/1ps
package rrv_pkg;

    // Reason the pointer moves in a given cycle
    typedef enum logic [1:0] {
        ADV_NONE = 2'b00,
        ADV_HIT  = 2'b01,
        ADV_FILL = 2'b10,
        ADV_BOTH = 2'b11
    } adv_cause_e;

endpackage

// File: rtl/rrv_hit_detect.sv
`timescale 1ns/1ps
module rrv_hit_detect #(
    parameter int IDX_W = 6
) (
    input  logic             acc_vld,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [IDX_W-1:0] ptr,
    input  logic             fill_req,
    output rrv_pkg::adv_cause_e cause
);
    import rrv_pkg::*;

    logic hit_on_ptr;

    always_comb begin
        hit_on_ptr = acc_vld && (acc_idx == ptr);
        case ({fill_req, hit_on_ptr})
            2'b01:   cause = ADV_HIT;
            2'b10:   cause = ADV_FILL;
            2'b11:   cause = ADV_BOTH;
            default: cause = ADV_NONE;
        endcase
    end

endmodule

// File: rtl/rrv_ptr_step.sv
`timescale 1ns/1ps
module rrv_ptr_step #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0] cur,
    input  logic             adv,
    output logic [IDX_W-1:0] nxt
);
    localparam bit POW2 = ((1 << IDX_W) == ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] inc;

    generate
        if (POW2) begin : g_pow2
            // natural wrap of the counter width
            always_comb inc = cur + 1'b1;
        end else begin : g_mod
            always_comb inc = (cur == LAST) ? '0 : cur + 1'b1;
        end
    endgenerate

    always_comb nxt = adv ? inc : cur;

endmodule

// File: rtl/rrv_victim_sel.sv
`timescale 1ns/1ps
module rrv_victim_sel #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             fill_req,
    output logic [IDX_W-1:0] victim_idx
);
    import rrv_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } sel_state_t;

    sel_state_t st_d, st_q;
    adv_cause_e cause;
    logic       adv;
    logic [IDX_W-1:0] ptr_nxt;

    rrv_hit_detect #(.IDX_W(IDX_W)) u_hit (
        .acc_vld  (acc_vld),
        .acc_idx  (acc_idx),
        .ptr      (st_q.ptr),
        .fill_req (fill_req),
        .cause    (cause)
    );

    rrv_ptr_step #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_step (
        .cur (st_q.ptr),
        .adv (adv),
        .nxt (ptr_nxt)
    );

    always_comb begin
        // any cause, or both together, gives a single step
        adv    = (cause != ADV_NONE);
        st_d   = st_q;
        st_d.ptr = ptr_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_idx = st_q.ptr;

endmodule

// File: rtl/rrv_victim_sel_chk.sv
`timescale 1ns/1ps
module rrv_victim_sel_chk #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_vld,
    input logic [IDX_W-1:0] acc_idx,
    input logic             fill_req,
    input logic [IDX_W-1:0] victim_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R1: reset leaves the victim at entry 0
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> victim_idx == '0);

    // R3 / R8: hit on the pointed entry gives exactly one step
    a_r3_hit_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_idx == victim_idx) |=>
        victim_idx == (($past(victim_idx) == LAST) ? '0 : $past(victim_idx) + 1'b1));

    // R4 / R5: nothing moves the pointer without a pointed hit or a fill
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_req && !(acc_vld && acc_idx == victim_idx)) |=> $stable(victim_idx));

    // R7 / R9: a fill gives exactly one step
    a_r7_fill_steps: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=>
        victim_idx == (($past(victim_idx) == LAST) ? '0 : $past(victim_idx) + 1'b1));

    // R10: a just-accessed entry is not the next victim
    a_r10_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !fill_req) |=> victim_idx != $past(acc_idx));

endmodule

bind rrv_victim_sel rrv_victim_sel_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_idx    (acc_idx),
    .fill_req   (fill_req),
    .victim_idx (victim_idx)
);

// File: tb/rrv_victim_sel_test.sv
`timescale 1ns/1ps
module rrv_victim_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_vld = 1'b0;
    logic [5:0] acc_idx = '0;
    logic       fill_req = 1'b0;
    logic [5:0] victim_idx;

    int vectors = 0;
    int miscompares = 0;
    int ref_ptr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rrv_victim_sel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_vld    (acc_vld),
        .acc_idx    (acc_idx),
        .fill_req   (fill_req),
        .victim_idx (victim_idx)
    );

    task automatic check(input string tag, input int exp);
        vectors++;
        if (int'(victim_idx) != exp) begin
            miscompares++;
            $display("FAIL %s: victim_idx=%0d expected %0d at %0t", tag, victim_idx, exp, $time);
        end
    endtask

    // drive one cycle, update model at the edge, compare after it
    task automatic cyc(input bit a, input int idx, input bit f, input string tag);
        @(negedge clk);
        acc_vld  = a;
        acc_idx  = 6'(idx);
        fill_req = f;
        @(posedge clk);
        if (f || (a && idx == ref_ptr)) ref_ptr = (ref_ptr + 1) % 64;
        #1;
        check(tag, ref_ptr);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int hot;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1 during reset", 0);
        @(negedge clk) rst_n = 1'b1;
        ref_ptr = 0;
        #1 check("R1 after release", 0);
        cyc(0, 0, 0, "R1 first cycle");

        // R3: hits on the pointed entry step it
        for (int i = 0; i < 5; i++) cyc(1, ref_ptr, 0, "R3 pointed hit");
        // R4: other entries leave it
        for (int i = 0; i < 6; i++) cyc(1, (ref_ptr + 7 + i) % 64, 0, "R4 other hit");
        // R5: strobe low with matching index
        for (int i = 0; i < 4; i++) cyc(0, ref_ptr, 0, "R5 strobe low");
        // R7: fills
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, "R7 fill");
        // R2: output steady across idle cycles
        for (int i = 0; i < 3; i++) cyc(0, 17, 0, "R2 idle hold");
        // R6: walk to 63 then wrap, by hits and by fill
        while (ref_ptr != 63) cyc(0, 0, 1, "R6 walk");
        cyc(1, 63, 0, "R6 wrap by hit");
        while (ref_ptr != 63) cyc(1, ref_ptr, 0, "R6 walk hit");
        cyc(0, 0, 1, "R6 wrap by fill");
        // R8: fill and pointed hit together
        for (int i = 0; i < 4; i++) cyc(1, ref_ptr, 1, "R8 fill+hit");
        while (ref_ptr != 63) cyc(0, 0, 1, "R8 walk");
        cyc(1, 63, 1, "R8 fill+hit at wrap");
        // R9: fill with a hit elsewhere
        for (int i = 0; i < 4; i++) cyc(1, (ref_ptr + 1) % 64, 1, "R9 fill+other");
        cyc(1, (ref_ptr + 33) % 64, 1, "R9 fill+far");

        // R10: hammer one entry; it must never be the victim
        hot = (ref_ptr + 3) % 64;
        for (int i = 0; i < 150; i++) begin
            if (i % 3 == 0) cyc(0, 0, 1, "R10 fill");
            cyc(1, hot, 0, "R10 hammer");
            vectors++;
            if (int'(victim_idx) == hot) begin
                miscompares++;
                $display("FAIL R10: victim_idx=%0d expected not %0d", victim_idx, hot);
            end
        end

        // mixed stream
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[1] ? ref_ptr : int'(lfsr[9:4]), lfsr[2] & lfsr[3], "R8 R9 mix");
        end

        // reset mid-run
        @(negedge clk) rst_n = 1'b0;
        acc_vld = 1'b0; fill_req = 1'b0;
        ref_ptr = 0;
        #1 check("R1 async reset", 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(1, 0, 0, "R3 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule